// File: doc/BRIEF.md
# Configurable Registered Command/Address Buffer

This block is the clocked register on a memory module's command/address path. Each rising clock edge captures the incoming command/address bits and drives them one cycle later. The capture happens only when the device is selected by one of its two active-low chip-select inputs. When neither chip select is active, the outputs hold their previous values, so the output drivers do not toggle.

A two-bit configuration input sets the topology, and the block samples it only while reset is held.

- **One-to-one:** all 25 inputs are registered onto 25 primary outputs.
- **One-to-two:** 14 inputs are registered, and each is driven onto two output copies, a primary and a secondary. In this topology the device acts as one half of a two-device pair. The lower half takes the low 14 inputs, and the upper half takes the high 14 inputs.

Output bits that the chosen topology does not use are driven low. An asynchronous active-low reset clears every output.

Top module: `cmd_regbuf`

## Requirements
- R1: While `rstN` is low, `qPrimary` and `qSecondary` are all zero. Asserting `rstN` clears them at once, without waiting for a clock edge, and reset takes priority over the clock.
- R2: `cfgSel` is sampled on each rising clock edge while `rstN` is low and is held unchanged once reset is released. Encoding: `cfgSel[0]=0` selects one-to-one whatever the value of `cfgSel[1]`. `cfgSel[0]=1` selects one-to-two, and in that case `cfgSel[1]=0` is the lower half and `cfgSel[1]=1` is the upper half.
- R3: In one-to-one mode, after a rising edge at which the device is selected, `qPrimary` equals the `dIn` value present at that edge, and `qSecondary` is zero. The latency is one clock.
- R4: In one-to-two lower-half mode, after a selected edge, `qPrimary[13:0]` and `qSecondary[13:0]` both equal `dIn[13:0]` from that edge, and `qPrimary[24:14]` is zero.
- R5: In one-to-two upper-half mode, after a selected edge, `qPrimary[13:0]` and `qSecondary[13:0]` both equal `dIn[24:11]` from that edge, and `qPrimary[24:14]` is zero.
- R6: The device is selected when at least one bit of `csN` is low. When both bits are high at a rising edge, neither output changes at that edge.
- R7: Changing `cfgSel` while `rstN` is high has no effect on how later inputs are mapped to the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgSel | input | 2 | Topology selection, sampled during reset |
| csN | input | 2 | Active-low chip selects; either one low enables capture |
| dIn | input | 25 | Command/address inputs |
| qPrimary | output | 25 | Registered primary outputs |
| qSecondary | output | 14 | Registered second copy, used in one-to-two mode |

## Verification
The assertions take for granted that `cfgSel` is settled during at least one rising edge while `rstN` is low. Without such an edge the latched topology would be undefined after release. They also assume that `dIn` and `csN` are stable around each rising edge, so the value captured is the value sampled.

The stimulus meets these assumptions in three ways:
- It changes every input only on falling clock edges.
- It holds reset over several rising edges each time it applies a new topology.
- It changes `cfgSel` outside reset only to show that the change is ignored.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic loadEn;     // capture this edge
    logic dualMode;   // one-to-two topology
    logic upperHalf;  // take the high slice of dIn
  } strobe_t;

  // Latched topology; bit 0 = one-to-two, bit 1 = upper half.
  typedef enum logic [1:0] {
    CFG_SINGLE     = 2'b00,
    CFG_DUAL_LOW   = 2'b01,
    CFG_SINGLE_ALT = 2'b10,
    CFG_DUAL_HIGH  = 2'b11
  } cfg_e;

endpackage

// File: rtl/regbuf_ctrl.sv
module regbuf_ctrl
  import regbuf_pkg::*;
#(
  parameter int CS_BITS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         cfgSel,
  input  logic [CS_BITS-1:0] csN,
  output strobe_t            strobes
);

  cfg_e cfgQ;

  // Topology is taken only while reset is held.
  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= cfg_e'(cfgSel);
  end

  logic anySelected;
  assign anySelected = ~(&csN);

  always_comb begin
    strobes.loadEn    = rstN && anySelected;
    strobes.dualMode  = cfgQ[0];
    strobes.upperHalf = cfgQ[1];
  end

endmodule

// File: rtl/regbuf_dpath.sv
module regbuf_dpath
  import regbuf_pkg::*;
#(
  parameter int WIDE_BITS   = 25,
  parameter int NARROW_BITS = 14
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strobes,
  input  logic [WIDE_BITS-1:0]   dIn,
  output logic [WIDE_BITS-1:0]   qPrimary,
  output logic [NARROW_BITS-1:0] qSecondary
);

  localparam int UPPER_BASE = WIDE_BITS - NARROW_BITS;

  logic [NARROW_BITS-1:0] narrowSlice;
  logic [WIDE_BITS-1:0]   captureVal;
  logic [WIDE_BITS-1:0]   stateQ;

  // Half selection for the one-to-two topology.
  generate
    if (UPPER_BASE > 0) begin : g_split
      assign narrowSlice = strobes.upperHalf ? dIn[WIDE_BITS-1:UPPER_BASE]
                                             : dIn[NARROW_BITS-1:0];
    end else begin : g_nosplit
      assign narrowSlice = dIn[NARROW_BITS-1:0];
    end
  endgenerate

  always_comb begin
    captureVal = '0;
    if (strobes.dualMode) captureVal[NARROW_BITS-1:0] = narrowSlice;
    else                  captureVal = dIn;
  end

  // Single state register shared by both topologies.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               stateQ <= '0;
    else if (strobes.loadEn) stateQ <= captureVal;
  end

  assign qPrimary   = stateQ;
  assign qSecondary = strobes.dualMode ? stateQ[NARROW_BITS-1:0] : '0;

endmodule

// File: rtl/cmd_regbuf.sv
module cmd_regbuf
  import regbuf_pkg::*;
#(
  parameter int WIDE_BITS   = 25,
  parameter int NARROW_BITS = 14,
  parameter int CS_BITS     = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             cfgSel,
  input  logic [CS_BITS-1:0]     csN,
  input  logic [WIDE_BITS-1:0]   dIn,
  output logic [WIDE_BITS-1:0]   qPrimary,
  output logic [NARROW_BITS-1:0] qSecondary
);

  strobe_t strobes;

  regbuf_ctrl #(.CS_BITS(CS_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgSel(cfgSel), .csN(csN), .strobes(strobes)
  );

  regbuf_dpath #(.WIDE_BITS(WIDE_BITS), .NARROW_BITS(NARROW_BITS)) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dIn(dIn),
    .qPrimary(qPrimary), .qSecondary(qSecondary)
  );

endmodule

// File: rtl/cmd_regbuf_checker.sv
module cmd_regbuf_checker
  import regbuf_pkg::*;
#(
  parameter int WIDE_BITS   = 25,
  parameter int NARROW_BITS = 14,
  parameter int CS_BITS     = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [CS_BITS-1:0]     csN,
  input logic [WIDE_BITS-1:0]   dIn,
  input logic [WIDE_BITS-1:0]   qPrimary,
  input logic [NARROW_BITS-1:0] qSecondary,
  input strobe_t                strobes
);

  localparam int UPPER_BASE = WIDE_BITS - NARROW_BITS;

  // R1: outputs cleared whenever reset is low.
  assert_reset_clear_R1: assert property (@(negedge clk)
    !rstN |-> (qPrimary == '0 && qSecondary == '0));

  // R2 / R7: latched topology stays put outside reset.
  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ($stable(strobes.dualMode) && $stable(strobes.upperHalf)));

  // R3: one-to-one capture with one cycle latency.
  assert_single_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!(&csN) && !strobes.dualMode) |=> (qPrimary == $past(dIn) && qSecondary == '0));

  // R4: lower half copies.
  assert_dual_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!(&csN) && strobes.dualMode && !strobes.upperHalf)
      |=> (qSecondary == $past(dIn[NARROW_BITS-1:0])
           && qPrimary[NARROW_BITS-1:0] == $past(dIn[NARROW_BITS-1:0])));

  // R5: upper half copies.
  assert_dual_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!(&csN) && strobes.dualMode && strobes.upperHalf)
      |=> (qSecondary == $past(dIn[WIDE_BITS-1:UPPER_BASE])
           && qPrimary[NARROW_BITS-1:0] == $past(dIn[WIDE_BITS-1:UPPER_BASE])));

  // R4/R5: unused primary bits are low in one-to-two mode.
  assert_dual_unused_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dualMode |-> (qPrimary[WIDE_BITS-1:NARROW_BITS] == '0));

  // R6: no selection keeps outputs still.
  assert_deselect_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (&csN) |=> ($stable(qPrimary) && $stable(qSecondary)));

endmodule

bind cmd_regbuf cmd_regbuf_checker #(
  .WIDE_BITS(WIDE_BITS), .NARROW_BITS(NARROW_BITS), .CS_BITS(CS_BITS)
) chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .dIn(dIn),
  .qPrimary(qPrimary), .qSecondary(qSecondary), .strobes(strobes)
);

// File: tb/cmd_regbuf_tb_top.sv
`timescale 1ns/1ps
module cmd_regbuf_tb_top;

  localparam int WIDE   = 25;
  localparam int NARROW = 14;
  localparam int UBASE  = WIDE - NARROW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rstN   = 1'b0;
  logic [1:0]        cfgSel = 2'b00;
  logic [1:0]        csN    = 2'b11;
  logic [WIDE-1:0]   dIn    = '0;
  logic [WIDE-1:0]   qPrimary;
  logic [NARROW-1:0] qSecondary;

  cmd_regbuf dut_i (
    .clk(clk), .rstN(rstN), .cfgSel(cfgSel), .csN(csN), .dIn(dIn),
    .qPrimary(qPrimary), .qSecondary(qSecondary)
  );

  int checks = 0;
  int errors = 0;
  logic [1:0]        cfgModel = 2'b00;
  logic [WIDE-1:0]   expP = '0;
  logic [NARROW-1:0] expS = '0;

  function automatic logic [WIDE-1:0] mapP(logic [1:0] cfg, logic [WIDE-1:0] d);
    logic [WIDE-1:0] r;
    r = '0;
    if (!cfg[0]) r = d;
    else if (cfg[1]) r[NARROW-1:0] = d[WIDE-1:UBASE];
    else r[NARROW-1:0] = d[NARROW-1:0];
    return r;
  endfunction

  function automatic logic [NARROW-1:0] mapS(logic [1:0] cfg, logic [WIDE-1:0] d);
    if (!cfg[0]) return '0;
    return cfg[1] ? d[WIDE-1:UBASE] : d[NARROW-1:0];
  endfunction

  task automatic checkOut(string req);
    checks++;
    if (qPrimary !== expP || qSecondary !== expS) begin
      errors++;
      $display("FAIL %s: actual qPrimary=%h qSecondary=%h, expected %h %h",
               req, qPrimary, qSecondary, expP, expS);
    end
  endtask

  // Called at a falling edge; holds reset over three rising edges.
  task automatic applyReset(logic [1:0] cfg);
    rstN   = 1'b0;
    cfgSel = cfg;
    csN    = 2'b11;
    repeat (3) @(negedge clk);
    expP = '0;
    expS = '0;
    checkOut("R1");
    rstN     = 1'b1;
    cfgModel = cfg;
  endtask

  // Called at a falling edge; drives, lets one rising edge pass, checks.
  task automatic cycle(logic [WIDE-1:0] d, logic [1:0] cs, string req);
    dIn = d;
    csN = cs;
    @(posedge clk);
    if (cs != 2'b11) begin
      expP = mapP(cfgModel, d);
      expS = mapS(cfgModel, d);
    end
    @(negedge clk);
    checkOut(req);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=complete");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);

    // R1, R3: reset state, then one-to-one capture.
    applyReset(2'b00);
    cycle(25'h1FFFFFF, 2'b10, "R3");
    cycle(25'h0A5A5A5, 2'b01, "R3");
    // R6: both chip selects high -> hold.
    cycle(25'h1234567, 2'b11, "R6");
    cycle(25'h0000001, 2'b00, "R3");
    cycle(25'h1555555, 2'b11, "R6");
    // R7: change configuration out of reset, no effect.
    cfgSel = 2'b11;
    cycle(25'h1C0FFEE, 2'b00, "R7");
    cycle(25'h0F0F0F0, 2'b10, "R7");

    // R1: asynchronous clear mid-cycle, before any rising edge.
    #3 rstN = 1'b0;
    #1;
    expP = '0;
    expS = '0;
    checkOut("R1");
    @(negedge clk);

    // R4: lower half; upper input bits must not appear.
    applyReset(2'b01);
    cycle(25'h1FFC000, 2'b00, "R4");
    cycle(25'h0003FFF, 2'b01, "R4");
    cycle(25'h1ABCDEF, 2'b11, "R6");

    // R5: upper half.
    applyReset(2'b11);
    cycle(25'h00007FF, 2'b00, "R5");
    cycle(25'h1FFF800, 2'b10, "R5");
    cycle(25'h1234567, 2'b01, "R5");

    // R2: bit1 alone still one-to-one.
    applyReset(2'b10);
    cycle(25'h1FEDCBA, 2'b00, "R2");

    // Random stimulus across all encodings.
    for (int c = 0; c < 4; c++) begin
      logic [1:0] cfgPick;
      string tag;
      cfgPick = c[1:0];
      applyReset(cfgPick);
      tag = !cfgPick[0] ? "R3" : (cfgPick[1] ? "R5" : "R4");
      for (int i = 0; i < 60; i++) begin
        logic [1:0] csPick;
        csPick = ($urandom % 4 == 0) ? 2'b11 : 2'($urandom % 3);
        cycle(WIDE'($urandom), csPick, (csPick == 2'b11) ? "R6" : tag);
      end
    end

    finishRun();
  end

endmodule